// File: doc/BRIEF.md
# Cascadable Threshold Event Counters

This unit watches a bank of single-cycle event strobes coming from neighbouring logic (bus error detectors, FIFO guards, sync and line timing) and counts them on three independent channels. Channel 0 is twelve bits wide; channels 1 and 2 are ten bits wide. Each channel is steered to one strobe by a six-bit source code. It counts until it has reached its programmed limit, then wraps, emits a one-clock overflow pulse and latches a sticky status flag.

Overflow pulses are themselves selectable sources, so one channel can count the wraps of another and form a longer prescaler. A fourth overflow source code takes a cascade strobe from outside the unit, so a neighbouring unit can be chained in. Software programs the limits, sources and interrupt enables through a small word-wide register port. It clears status flags by writing ones to them and sees a single interrupt line.

Top module: `ectr_unit`

## Requirements
- R1: Register word 0 holds the limits: channel 2 in bits 31:22 (10 bits), channel 1 in bits 21:12 (10 bits), channel 0 in bits 11:0 (12 bits); every bit is writable and reads back as written.
- R2: Register word 1 holds the source codes: channel 0 in bits 5:0, channel 1 in bits 13:8, channel 2 in bits 21:16; all other bits read as zero.
- R3: Source code 0x2C+k (k = 0..15) selects strobe evtIn[k], except k = 13 (code 0x39), which is reserved. Codes 0x3C, 0x3D and 0x3E select the overflow pulse of channel 0, 1 and 2. Code 0x3F selects cascadeIn.
- R4: On each selected event a channel whose count is below its limit increments. If the count equals the limit, it wraps to zero and ovfOut[i] is high for exactly the following clock. A limit L therefore gives one pulse per L+1 events.
- R5: Status bit i (word 2, bit i) is set in the clock after an overflow pulse of channel i and stays set. Writing 1 to it at word 2 clears it; writing 0 leaves it. A set and a clear in the same clock leave it set.
- R6: The reserved code 0x39 and every code outside 0x2C..0x3F select nothing: the channel holds its count and never overflows.
- R7: Any write to word 0 or word 1 resets all three counts to zero and suppresses an overflow in that clock.
- R8: irq is the OR over channels of status bit i AND enable bit i; the enables sit in word 3 bits 2:0.
- R9: After reset all registers read zero, ovfOut is zero and irq is low.
- R10: A channel that selects another channel's overflow code counts that pulse in the clock in which it is visible on ovfOut.
- R11: Channel 0 counts over its full 12-bit range: with limit 4095 and an event on every clock it pulses once every 4096 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register word written |
| wrData | input | 32 | Write data |
| rdAddr | input | 2 | Register word read |
| rdData | output | 32 | Read data for rdAddr (combinational) |
| evtIn | input | 16 | Single-cycle event strobes, index 13 unused |
| cascadeIn | input | 1 | Cascade strobe from a neighbouring unit |
| ovfOut | output | 3 | One-clock overflow pulse per channel |
| irq | output | 1 | Enabled-status interrupt |

## Verification
A count that has drifted stays hidden until the channel overflows. It then shows on ovfOut one or more events early or late, and the next clock shows it in the status read-back and on irq. A wrong count can therefore take up to limit+1 selected events to appear. Small limits and per-clock comparison against a behavioural model are used to keep that window short. A wrong source decode or a lost clear shows on the first mismatching overflow. A broken chain link shows one clock after the upstream pulse.

// File: rtl/ectr_pkg.sv
package ectr_pkg;
  localparam int NCH        = 3;
  localparam int SEL_W      = 6;
  localparam int EVT_W      = 16;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 2;
  localparam int CNT0_W     = 12;
  localparam int CNTN_W     = 10;
  localparam int SEL_STRIDE = 8;
  localparam int EVT_IDX_W  = $clog2(EVT_W);
  localparam int OVF_IDX_W  = $clog2(NCH);

  localparam logic [ADDR_W-1:0] ADDR_THR  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_SEL  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 2'd3;

  localparam logic [SEL_W-1:0] CODE_FIRST    = 6'h2C;
  localparam logic [SEL_W-1:0] CODE_RSV      = 6'h39;
  localparam logic [SEL_W-1:0] CODE_OVF_FIRST = CODE_FIRST + SEL_W'(EVT_W);
  localparam logic [SEL_W-1:0] CODE_OVF_LAST  = CODE_OVF_FIRST + SEL_W'(NCH - 1);
  localparam logic [SEL_W-1:0] CODE_CASC     = 6'h3F;

  typedef struct packed {
    logic [NCH-1:0] clr;
  } ctlStrobe_t;

  function automatic int cntWidth(input int ch);
    return (ch == 0) ? CNT0_W : CNTN_W;
  endfunction

  function automatic int fieldLo(input int ch);
    int lo;
    lo = 0;
    for (int k = 0; k < ch; k++) lo += cntWidth(k);
    return lo;
  endfunction

  function automatic logic pickEvent(input logic [SEL_W-1:0] code,
                                     input logic [EVT_W-1:0] ext,
                                     input logic [NCH-1:0]   ovf,
                                     input logic             casc);
    logic hit;
    logic [SEL_W-1:0] off;
    hit = 1'b0;
    if (code >= CODE_FIRST && code < CODE_OVF_FIRST) begin
      off = code - CODE_FIRST;
      if (code != CODE_RSV) hit = ext[off[EVT_IDX_W-1:0]];
    end else if (code >= CODE_OVF_FIRST && code <= CODE_OVF_LAST) begin
      off = code - CODE_OVF_FIRST;
      hit = ovf[off[OVF_IDX_W-1:0]];
    end else if (code == CODE_CASC) begin
      hit = casc;
    end
    return hit;
  endfunction
endpackage

// File: rtl/ectr_ctrl.sv
module ectr_ctrl
  import ectr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [ADDR_W-1:0]             rdAddr,
  input  logic [NCH-1:0]                ovfIn,
  output logic [DATA_W-1:0]             rdData,
  output logic                          irq,
  output ctlStrobe_t                    strb,
  output logic [DATA_W-1:0]             thrReg,
  output logic [NCH-1:0][SEL_W-1:0]     selReg
);
  logic [DATA_W-1:0]         thrQ;
  logic [NCH-1:0][SEL_W-1:0] selQ;
  logic [NCH-1:0]            statQ;
  logic [NCH-1:0]            enQ;
  logic [NCH-1:0]            w1c;
  logic                      cfgWrite;

  assign cfgWrite = wrEn && (wrAddr == ADDR_THR || wrAddr == ADDR_SEL);
  assign strb.clr = {NCH{cfgWrite}};
  assign w1c      = (wrEn && wrAddr == ADDR_STAT) ? wrData[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrQ  <= '0;
      selQ  <= '0;
      enQ   <= '0;
      statQ <= '0;
    end else begin
      statQ <= (statQ & ~w1c) | ovfIn;
      if (wrEn) begin
        case (wrAddr)
          ADDR_THR: thrQ <= wrData;
          ADDR_SEL:
            for (int i = 0; i < NCH; i++) selQ[i] <= wrData[i*SEL_STRIDE +: SEL_W];
          ADDR_EN:  enQ <= wrData[NCH-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_THR: rdData = thrQ;
      ADDR_SEL:
        for (int i = 0; i < NCH; i++) rdData[i*SEL_STRIDE +: SEL_W] = selQ[i];
      ADDR_STAT: rdData[NCH-1:0] = statQ;
      default:   rdData[NCH-1:0] = enQ;
    endcase
  end

  assign irq    = |(statQ & enQ);
  assign thrReg = thrQ;
  assign selReg = selQ;

  for (genvar g = 0; g < NCH; g++) begin : gStatChk
    assert_status_set_R5: assert property (@(posedge clk) disable iff (!rstN)
      ovfIn[g] |=> statQ[g])
      else $error("status bit %0d missed an overflow", g);
    assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
      (statQ[g] && !w1c[g]) |=> statQ[g])
      else $error("status bit %0d dropped without clear", g);
  end
endmodule

// File: rtl/ectr_datapath.sv
module ectr_datapath
  import ectr_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobe_t                strb,
  input  logic [DATA_W-1:0]         thrReg,
  input  logic [NCH-1:0][SEL_W-1:0] selReg,
  input  logic [EVT_W-1:0]          evtIn,
  input  logic                      cascadeIn,
  output logic [NCH-1:0]            ovfQ
);
  for (genvar g = 0; g < NCH; g++) begin : gChan
    localparam int W  = cntWidth(g);
    localparam int LO = fieldLo(g);

    logic [W-1:0] cnt;
    logic [W-1:0] limit;
    logic         evt;
    logic         ovfBit;

    assign limit = thrReg[LO +: W];
    assign evt   = pickEvent(selReg[g], evtIn, ovfQ, cascadeIn);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt    <= '0;
        ovfBit <= 1'b0;
      end else if (strb.clr[g]) begin
        cnt    <= '0;
        ovfBit <= 1'b0;
      end else if (evt) begin
        if (cnt == limit) begin
          cnt    <= '0;
          ovfBit <= 1'b1;
        end else begin
          cnt    <= cnt + 1'b1;
          ovfBit <= 1'b0;
        end
      end else begin
        ovfBit <= 1'b0;
      end
    end

    assign ovfQ[g] = ovfBit;

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
      cnt <= limit)
      else $error("channel %0d count above limit", g);
    assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
      ovfBit |-> cnt == '0)
      else $error("channel %0d pulsed without wrapping", g);
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
      strb.clr[g] |=> (cnt == '0 && !ovfBit))
      else $error("channel %0d not cleared by config write", g);
  end
endmodule

// File: rtl/ectr_unit.sv
module ectr_unit
  import ectr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [1:0]  rdAddr,
  output logic [31:0] rdData,
  input  logic [15:0] evtIn,
  input  logic        cascadeIn,
  output logic [2:0]  ovfOut,
  output logic        irq
);
  ctlStrobe_t                strb;
  logic [DATA_W-1:0]         thrReg;
  logic [NCH-1:0][SEL_W-1:0] selReg;
  logic [NCH-1:0]            ovf;

  ectr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .ovfIn(ovf), .rdData(rdData), .irq(irq),
    .strb(strb), .thrReg(thrReg), .selReg(selReg)
  );

  ectr_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .thrReg(thrReg), .selReg(selReg),
    .evtIn(evtIn), .cascadeIn(cascadeIn), .ovfQ(ovf)
  );

  assign ovfOut = ovf;
endmodule

// File: tb/ectr_unit_tb_top.sv
`timescale 1ns/1ps
module ectr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [15:0] evtIn = '0;
  logic        cascadeIn = 1'b0;
  logic [2:0]  ovfOut;
  logic        irq;

  always #2.5 clk = ~clk;

  ectr_unit dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evtIn(evtIn), .cascadeIn(cascadeIn),
    .ovfOut(ovfOut), .irq(irq)
  );

  int nChecks = 0;
  int nErr = 0;
  int cyc = 0;
  bit done = 0;
  bit live = 0;
  int ovfSeen[3];

  logic [31:0] mThr;
  int  mSel[3];
  int  mCnt[3];
  bit  mOvf[3];
  bit  nOvf[3];
  bit  mSt[3];
  bit [2:0] mEn;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int limitOf(input int ch);
    if (ch == 0) return int'(mThr[11:0]);
    if (ch == 1) return int'(mThr[21:12]);
    return int'(mThr[31:22]);
  endfunction

  function automatic bit modelEvt(input int code);
    if (code >= 44 && code <= 59) return (code == 57) ? 1'b0 : evtIn[code-44];
    if (code >= 60 && code <= 62) return mOvf[code-60];
    if (code == 63) return cascadeIn;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mThr = '0; mEn = '0;
      for (int i = 0; i < 3; i++) begin mSel[i] = 0; mCnt[i] = 0; mOvf[i] = 0; mSt[i] = 0; end
    end else begin
      for (int i = 0; i < 3; i++) begin
        nOvf[i] = 0;
        if (wrEn && (wrAddr == 0 || wrAddr == 1)) mCnt[i] = 0;
        else if (modelEvt(mSel[i])) begin
          if (mCnt[i] == limitOf(i)) begin mCnt[i] = 0; nOvf[i] = 1; end
          else mCnt[i] = mCnt[i] + 1;
        end
      end
      for (int i = 0; i < 3; i++)
        mSt[i] = (mSt[i] && !(wrEn && wrAddr == 2 && wrData[i])) || mOvf[i];
      if (wrEn) begin
        if (wrAddr == 0) mThr = wrData;
        if (wrAddr == 1) begin
          mSel[0] = int'(wrData[5:0]); mSel[1] = int'(wrData[13:8]); mSel[2] = int'(wrData[21:16]);
        end
        if (wrAddr == 3) mEn = wrData[2:0];
      end
      for (int i = 0; i < 3; i++) mOvf[i] = nOvf[i];
    end
  end

  function automatic logic [31:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return mThr;
      2'd1: return 32'(mSel[0]) | (32'(mSel[1]) << 8) | (32'(mSel[2]) << 16);
      2'd2: return {29'd0, mSt[2], mSt[1], mSt[0]};
      default: return {29'd0, mEn};
    endcase
  endfunction

  always @(negedge clk) begin
    #1;
    if (live) begin
      logic [2:0] eo;
      logic ei;
      eo = {mOvf[2], mOvf[1], mOvf[0]};
      ei = |({mSt[2], mSt[1], mSt[0]} & mEn);
      check(ovfOut === eo, "R4 overflow pulses", {29'd0, ovfOut}, {29'd0, eo});
      check(irq === ei, "R8 irq", {31'd0, irq}, {31'd0, ei});
      check(rdData === expRead(rdAddr), "R5 register readback", rdData, expRead(rdAddr));
      for (int i = 0; i < 3; i++) if (ovfOut[i] === 1'b1) ovfSeen[i]++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      nChecks++; nErr++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic pulse(input logic [15:0] m, input bit c);
    @(negedge clk); evtIn = m; cascadeIn = c;
    @(negedge clk); evtIn = '0; cascadeIn = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    #2;
  endtask

  int base0, base1;

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    #2;
    // R9 reset state
    for (int a = 0; a < 4; a++) begin
      rdAddr = 2'(a); #0.5;
      check(rdData === 32'd0, "R9 reset readback", rdData, 32'd0);
    end
    check(ovfOut === 3'd0, "R9 reset ovf", {29'd0, ovfOut}, 32'd0);
    check(irq === 1'b0, "R9 reset irq", {31'd0, irq}, 32'd0);
    live = 1;

    // R1 limit layout
    wr(0, 32'hFFFF_FFFF); rdAddr = 0; settle();
    check(rdData === 32'hFFFF_FFFF, "R1 all limit bits", rdData, 32'hFFFF_FFFF);
    wr(0, 32'h0080_3004); settle();
    check(rdData === 32'h0080_3004, "R1 limit fields", rdData, 32'h0080_3004);

    // R2 select layout
    rdAddr = 1;
    wr(1, 32'hFFFF_FFFF); settle();
    check(rdData === 32'h003F_3F3F, "R2 select fields", rdData, 32'h003F_3F3F);
    wr(1, 32'h003C_3A2C); settle();

    // R4 limit 4 on channel 0 -> one pulse per five events, R10 channel 2 counts them
    rdAddr = 2;
    base0 = ovfSeen[0];
    repeat (4) pulse(16'h0001, 0);
    settle();
    check(ovfSeen[0] == base0, "R4 no pulse before limit", 32'(ovfSeen[0] - base0), 0);
    pulse(16'h0001, 0); settle();
    check(ovfSeen[0] == base0 + 1, "R4 pulse at limit", 32'(ovfSeen[0] - base0), 1);
    base1 = ovfSeen[2];
    repeat (10) pulse(16'h0001, 0);
    settle();
    check(ovfSeen[2] == base1 + 1, "R10 chained channel 2", 32'(ovfSeen[2] - base1), 1);

    // R5 write-one-to-clear, R8 enables
    wr(3, 32'h1); settle();
    check(irq === 1'b1, "R8 irq enabled", {31'd0, irq}, 1);
    wr(2, 32'h6); settle();
    check(rdData[0] === 1'b1, "R5 write zero keeps", rdData, 32'h1);
    wr(2, 32'h7); settle();
    check(rdData === 32'd0, "R5 clear all", rdData, 32'd0);
    check(irq === 1'b0, "R8 irq drops", {31'd0, irq}, 0);

    // R6 reserved and out-of-range codes with limit 0
    wr(0, 32'h0); wr(1, 32'h0000_1039);
    base0 = ovfSeen[0] + ovfSeen[1] + ovfSeen[2];
    @(negedge clk); evtIn = 16'hFFFF; cascadeIn = 1;
    repeat (50) @(negedge clk);
    evtIn = '0; cascadeIn = 0; settle();
    check((ovfSeen[0] + ovfSeen[1] + ovfSeen[2]) == base0, "R6 unused codes count nothing",
          32'(ovfSeen[0] + ovfSeen[1] + ovfSeen[2] - base0), 0);
    check(rdData === 32'd0, "R6 status untouched", rdData, 32'd0);

    // R3 source map on channel 1, limit 0
    for (int k = 0; k < 16; k++) begin
      wr(1, 32'(8'h2C + k) << 8);
      base1 = ovfSeen[1];
      pulse(~(16'h1 << k), 1); settle();
      check(ovfSeen[1] == base1, "R3 other strobes ignored", 32'(ovfSeen[1] - base1), 0);
      pulse(16'h1 << k, 0); settle();
      check(ovfSeen[1] == base1 + ((k == 13) ? 0 : 1), "R3 strobe map",
            32'(ovfSeen[1] - base1), (k == 13) ? 0 : 1);
    end
    wr(1, 32'h0000_3F00);
    base1 = ovfSeen[1];
    pulse(16'hFFFF, 1); settle();
    check(ovfSeen[1] == base1 + 1, "R3 cascade input", 32'(ovfSeen[1] - base1), 1);

    // R7 config write clears counts
    wr(0, 32'h5); wr(1, 32'h2C);
    base0 = ovfSeen[0];
    repeat (3) pulse(16'h1, 0);
    wr(1, 32'h2C);
    repeat (5) pulse(16'h1, 0);
    settle();
    check(ovfSeen[0] == base0, "R7 cleared count no early pulse", 32'(ovfSeen[0] - base0), 0);
    pulse(16'h1, 0); settle();
    check(ovfSeen[0] == base0 + 1, "R7 pulse after full run", 32'(ovfSeen[0] - base0), 1);

    // randomized chained traffic with W1C writes (R5 set-wins, R10)
    wr(0, 32'h0080_2001); wr(1, 32'h003D_3C30); wr(3, 32'h5);
    rdAddr = 2;
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      evtIn = 16'($urandom); cascadeIn = 1'($urandom);
      wrEn = (n % 7 == 0); wrAddr = 2; wrData = $urandom;
    end
    @(negedge clk); wrEn = 0; evtIn = '0; cascadeIn = 0;
    settle();

    // R11 full 12-bit range on channel 0
    wr(0, 32'h0000_0FFF); wr(1, 32'h2C);
    base0 = ovfSeen[0];
    @(negedge clk); evtIn = 16'h1;
    repeat (8192) @(negedge clk);
    evtIn = '0; settle();
    check(ovfSeen[0] == base0 + 2, "R11 twelve-bit wrap", 32'(ovfSeen[0] - base0), 2);

    live = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule